// File: doc/BRIEF.md
# Non-Blocking Load/Store Scoreboard

This block lets an in-order, single-issue pipeline keep issuing instructions while a load or store is still in flight. Memory can be slow, and a multiple-register transfer can take several beats. The decoder presents one instruction per cycle on the issue port. The block answers with a stall only when that instruction truly depends on a register whose load data has not yet returned. It also stalls when the instruction would overwrite a register that an outstanding store has not yet read. Instructions complete out of program order: ALU results retire while the memory operation is still running.

One memory operation is tracked at a time. A load or store carries a register list, and a single transfer is simply a list with one bit set. The list is walked from the lowest to the highest register number, two registers per beat over a 64-bit data bus. A lone remaining register goes out in the final beat. Load data returns through two dedicated write ports (port 0 and port 1) that are separate from the execute write port. The lower-numbered register of a pair always uses port 0.

The sequencer has three states. In IDLE no memory operation is outstanding. LOAD means beats of a load list are in progress. STORE means beats of a store list are in progress. The transitions are:
- IDLE→LOAD when a load with a non-empty list is accepted.
- IDLE→STORE when a store with a non-empty list is accepted.
- LOAD→IDLE or STORE→IDLE when the beat that empties the list completes.
- Every other case stays in the current state.

Top module: `nb_lsu_scoreboard`

## Requirements
- R1: After reset, `mem_req`, `wb0_en`, `wb1_en` and `iss_stall` are all 0.
- R2: While a load is outstanding whose list lacks register 15, an ALU instruction is not stalled if it reads no pending register and writes no pending register. The ALU kind codes are `iss_kind` 0 and 3.
- R3: An ALU instruction that reads a pending register (`iss_ra`/`iss_rb` with its use flag) is stalled. This holds up to and including the cycle in which that register's data is written back. The stall is released in the following cycle.
- R4: An ALU instruction whose destination `iss_rd` (with `iss_rd_we`) is a pending load register is stalled.
- R5: A list is walked lowest register first, two per beat. The lower register of a pair is on `wb0_*` and takes `mem_rdata[31:0]`. The higher register is on `wb1_*` and takes `mem_rdata[63:32]`, with `mem_two`=1. A lone last register uses `wb0_*` and the low word, with `mem_two`=0. The first beat addresses the issued base, and each later beat adds 8.
- R6: A beat completes only in a cycle where `mem_req` and `mem_ready` are both 1. Until then the address, the register numbers and the direction hold, and no write-back occurs.
- R7: While a memory operation is outstanding, a load (`iss_kind`=1) or a store (`iss_kind`=2) is stalled. A memory operation is accepted in any cycle in which none is outstanding.
- R8: While a load whose list includes register 15 is outstanding, every instruction is stalled. Issue resumes in the cycle after its last beat.
- R9: A store drives `mem_wr`=1 and never asserts a write-back port. An ALU write to a register the store has not yet read is stalled until the cycle after the beat that reads it. ALU reads of that register are not stalled.
- R10: A load or store with an empty list is accepted without stalling and starts no memory request.
- R11: Write-back happens in the same cycle as the completing beat, and only for registers that are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction presented for issue |
| iss_kind | input | 2 | 0 ALU, 1 load, 2 store, 3 treated as ALU |
| iss_ra | input | 4 | First source register (base for memory ops) |
| iss_ra_use | input | 1 | First source is read |
| iss_rb | input | 4 | Second source register |
| iss_rb_use | input | 1 | Second source is read |
| iss_rd | input | 4 | ALU destination register |
| iss_rd_we | input | 1 | ALU destination is written |
| iss_list | input | 16 | Register list of a load/store |
| iss_addr | input | 32 | Base byte address of a load/store |
| iss_stall | output | 1 | Issue held this cycle |
| mem_req | output | 1 | Data memory beat requested |
| mem_wr | output | 1 | Beat is a store |
| mem_addr | output | 32 | Beat byte address |
| mem_two | output | 1 | Beat carries two registers |
| mem_reg0 | output | 4 | Register in the low word |
| mem_reg1 | output | 4 | Register in the high word |
| mem_rdata | input | 64 | Load data |
| mem_ready | input | 1 | Beat completes this cycle |
| wb0_en | output | 1 | Load write port 0 enable |
| wb0_reg | output | 4 | Load write port 0 register |
| wb0_data | output | 32 | Load write port 0 data |
| wb1_en | output | 1 | Load write port 1 enable |
| wb1_reg | output | 4 | Load write port 1 register |
| wb1_data | output | 32 | Load write port 1 data |

## Verification
A wrong pending mask shows at the issue port in the next cycle. Either an independent instruction stalls, or a dependent one slips through. The bench sweeps every source and destination number against a known mask to catch both cases. A wrong remaining list or beat address shows on the memory port at the next beat. It appears as a skipped or repeated register, a wrong pairing, or a wrong address, and every list over the low eight registers is walked beat by beat. A sequencer stuck outside IDLE shows one cycle after the final beat as a request that stays high or a memory operation that stays stalled.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;

    typedef enum logic [1:0] {
        K_ALU   = 2'd0,
        K_LOAD  = 2'd1,
        K_STORE = 2'd2,
        K_ALT   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_STORE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sb_pair_pick.sv
`timescale 1ns/1ps
module sb_pair_pick #(
    parameter int NREG = 16,
    localparam int REG_AW = $clog2(NREG)
) (
    input  logic [NREG-1:0]   list,
    output logic              lo_ok,
    output logic [REG_AW-1:0] lo_idx,
    output logic              hi_ok,
    output logic [REG_AW-1:0] hi_idx,
    output logic [NREG-1:0]   beat_mask
);

    logic [NREG-1:0] rest;

    always_comb begin
        lo_ok  = 1'b0;
        lo_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (list[i]) begin
                lo_ok  = 1'b1;
                lo_idx = REG_AW'(i);
            end
        end
        rest = list;
        if (lo_ok) rest[lo_idx] = 1'b0;
        hi_ok  = 1'b0;
        hi_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (rest[i]) begin
                hi_ok  = 1'b1;
                hi_idx = REG_AW'(i);
            end
        end
        beat_mask = '0;
        if (lo_ok) beat_mask[lo_idx] = 1'b1;
        if (hi_ok) beat_mask[hi_idx] = 1'b1;
    end

endmodule

// File: rtl/sb_hazard.sv
`timescale 1ns/1ps
module sb_hazard
    import sb_pkg::*;
#(
    parameter int NREG = 16,
    localparam int REG_AW = $clog2(NREG)
) (
    input  logic              iss_valid,
    input  logic [1:0]        iss_kind,
    input  logic [REG_AW-1:0] iss_ra,
    input  logic              iss_ra_use,
    input  logic [REG_AW-1:0] iss_rb,
    input  logic              iss_rb_use,
    input  logic [REG_AW-1:0] iss_rd,
    input  logic              iss_rd_we,
    input  logic [NREG-1:0]   pend,
    input  logic [NREG-1:0]   smask,
    input  logic              pc_lock,
    input  logic              busy,
    output logic              stall
);

    kind_e kind;
    logic  is_mem;
    logic  raw_hit;
    logic  waw_hit;
    logic  war_hit;
    logic  hazard;

    always_comb begin
        kind    = kind_e'(iss_kind);
        is_mem  = (kind == K_LOAD) || (kind == K_STORE);
        raw_hit = (iss_ra_use && pend[iss_ra]) || (iss_rb_use && pend[iss_rb]);
        waw_hit = iss_rd_we && pend[iss_rd];
        war_hit = iss_rd_we && smask[iss_rd];
        if (is_mem) hazard = busy;
        else        hazard = raw_hit || waw_hit || war_hit;
        stall = iss_valid && (hazard || pc_lock);
    end

endmodule

// File: rtl/sb_seq.sv
`timescale 1ns/1ps
module sb_seq
    import sb_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int REG_AW     = $clog2(NREG),
    localparam int BUS_W      = 2 * DATA_W,
    localparam int BEAT_BYTES = BUS_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [1:0]        iss_kind,
    input  logic [NREG-1:0]   iss_list,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic [BUS_W-1:0]  mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic [NREG-1:0]   pend,
    output logic [NREG-1:0]   smask,
    output logic              pc_lock,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_two,
    output logic [REG_AW-1:0] mem_reg0,
    output logic [REG_AW-1:0] mem_reg1,
    output logic              wb0_en,
    output logic [REG_AW-1:0] wb0_reg,
    output logic [DATA_W-1:0] wb0_data,
    output logic              wb1_en,
    output logic [REG_AW-1:0] wb1_reg,
    output logic [DATA_W-1:0] wb1_data
);

    seq_state_e        state, nxt;
    logic [NREG-1:0]   rem;
    logic [ADDR_W-1:0] addr_q;
    logic              lo_ok, hi_ok;
    logic [REG_AW-1:0] lo_idx, hi_idx;
    logic [NREG-1:0]   beat_mask;
    logic [NREG-1:0]   left;
    logic              beat_done;
    logic              last_beat;
    logic              start_ld;
    logic              start_st;
    kind_e             kind;

    sb_pair_pick #(.NREG(NREG)) u_pick (
        .list      (rem),
        .lo_ok     (lo_ok),
        .lo_idx    (lo_idx),
        .hi_ok     (hi_ok),
        .hi_idx    (hi_idx),
        .beat_mask (beat_mask)
    );

    // next state and outputs
    always_comb begin
        kind      = kind_e'(iss_kind);
        left      = rem & ~beat_mask;
        beat_done = (state != ST_IDLE) && mem_ready;
        last_beat = beat_done && (left == '0);
        start_ld  = accept && (kind == K_LOAD)  && (|iss_list);
        start_st  = accept && (kind == K_STORE) && (|iss_list);
        nxt       = state;
        unique case (state)
            ST_IDLE: begin
                if (start_ld)      nxt = ST_LOAD;
                else if (start_st) nxt = ST_STORE;
            end
            ST_LOAD:  if (last_beat) nxt = ST_IDLE;
            ST_STORE: if (last_beat) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase

        busy     = (state != ST_IDLE);
        mem_req  = busy;
        mem_wr   = (state == ST_STORE);
        mem_addr = addr_q;
        mem_two  = busy && hi_ok;
        mem_reg0 = lo_idx;
        mem_reg1 = hi_idx;
        wb0_en   = (state == ST_LOAD) && mem_ready && lo_ok;
        wb0_reg  = lo_idx;
        wb0_data = mem_rdata[DATA_W-1:0];
        wb1_en   = (state == ST_LOAD) && mem_ready && hi_ok;
        wb1_reg  = hi_idx;
        wb1_data = mem_rdata[BUS_W-1:DATA_W];
    end

    // state register and tracking masks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rem     <= '0;
            pend    <= '0;
            smask   <= '0;
            pc_lock <= 1'b0;
            addr_q  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) begin
                if (start_ld || start_st) begin
                    rem    <= iss_list;
                    addr_q <= iss_addr;
                end
                if (start_ld) begin
                    pend    <= iss_list;
                    pc_lock <= iss_list[NREG-1];
                end
                if (start_st) smask <= iss_list;
            end else if (beat_done) begin
                rem    <= left;
                pend   <= pend & ~beat_mask;
                smask  <= smask & ~beat_mask;
                addr_q <= addr_q + ADDR_W'(BEAT_BYTES);
                if (last_beat) pc_lock <= 1'b0;
            end
        end
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_reg0)
                                     && $stable(mem_reg1) && $stable(mem_wr)))
        else $error("beat fields moved while waiting for ready");

    p_wb_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wb0_en |-> pend[wb0_reg]) and (wb1_en |-> pend[wb1_reg]))
        else $error("write-back to a register that was not pending");

    p_pair_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb1_en |-> (wb0_en && (wb1_reg > wb0_reg)))
        else $error("pair not in ascending order on write ports");

    p_idle_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> ((pend == '0) && (smask == '0) && !pc_lock))
        else $error("tracking state left over in IDLE");

    p_store_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (!wb0_en && !wb1_en))
        else $error("store drove a write-back port");

endmodule

// File: rtl/nb_lsu_scoreboard.sv
`timescale 1ns/1ps
module nb_lsu_scoreboard
    import sb_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int REG_AW = $clog2(NREG),
    localparam int BUS_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [1:0]        iss_kind,
    input  logic [REG_AW-1:0] iss_ra,
    input  logic              iss_ra_use,
    input  logic [REG_AW-1:0] iss_rb,
    input  logic              iss_rb_use,
    input  logic [REG_AW-1:0] iss_rd,
    input  logic              iss_rd_we,
    input  logic [NREG-1:0]   iss_list,
    input  logic [ADDR_W-1:0] iss_addr,
    output logic              iss_stall,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_two,
    output logic [REG_AW-1:0] mem_reg0,
    output logic [REG_AW-1:0] mem_reg1,
    input  logic [BUS_W-1:0]  mem_rdata,
    input  logic              mem_ready,
    output logic              wb0_en,
    output logic [REG_AW-1:0] wb0_reg,
    output logic [DATA_W-1:0] wb0_data,
    output logic              wb1_en,
    output logic [REG_AW-1:0] wb1_reg,
    output logic [DATA_W-1:0] wb1_data
);

    logic            busy;
    logic            pc_lock;
    logic [NREG-1:0] pend;
    logic [NREG-1:0] smask;
    logic            accept;

    assign accept = iss_valid && !iss_stall;

    sb_hazard #(.NREG(NREG)) u_haz (
        .iss_valid  (iss_valid),
        .iss_kind   (iss_kind),
        .iss_ra     (iss_ra),
        .iss_ra_use (iss_ra_use),
        .iss_rb     (iss_rb),
        .iss_rb_use (iss_rb_use),
        .iss_rd     (iss_rd),
        .iss_rd_we  (iss_rd_we),
        .pend       (pend),
        .smask      (smask),
        .pc_lock    (pc_lock),
        .busy       (busy),
        .stall      (iss_stall)
    );

    sb_seq #(.NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .iss_kind  (iss_kind),
        .iss_list  (iss_list),
        .iss_addr  (iss_addr),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .busy      (busy),
        .pend      (pend),
        .smask     (smask),
        .pc_lock   (pc_lock),
        .mem_req   (mem_req),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_two   (mem_two),
        .mem_reg0  (mem_reg0),
        .mem_reg1  (mem_reg1),
        .wb0_en    (wb0_en),
        .wb0_reg   (wb0_reg),
        .wb0_data  (wb0_data),
        .wb1_en    (wb1_en),
        .wb1_reg   (wb1_reg),
        .wb1_data  (wb1_data)
    );

    p_mem_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && iss_valid && ((iss_kind == 2'd1) || (iss_kind == 2'd2))) |-> iss_stall)
        else $error("second memory operation issued while one outstanding");

    p_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_kind == 2'd0) && iss_ra_use && pend[iss_ra]) |-> iss_stall)
        else $error("read of pending register issued");

    p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb0_en && (wb0_reg == REG_AW'(NREG-1)) || wb1_en && (wb1_reg == REG_AW'(NREG-1)))
            |-> (iss_valid -> iss_stall))
        else $error("issue allowed while program counter load in flight");

    p_idle_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && !(iss_valid && !iss_stall && (iss_kind == 2'd1 || iss_kind == 2'd2)))
            |=> !mem_req)
        else $error("request started without an accepted memory operation");

endmodule

// File: tb/tb_nb_lsu_scoreboard.sv
`timescale 1ns/1ps
module tb_nb_lsu_scoreboard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_kind = 2'd0;
    logic [3:0]  iss_ra = '0, iss_rb = '0, iss_rd = '0;
    logic        iss_ra_use = 1'b0, iss_rb_use = 1'b0, iss_rd_we = 1'b0;
    logic [15:0] iss_list = '0;
    logic [31:0] iss_addr = '0;
    logic        iss_stall;
    logic        mem_req, mem_wr, mem_two;
    logic [31:0] mem_addr;
    logic [3:0]  mem_reg0, mem_reg1;
    logic [63:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        wb0_en, wb1_en;
    logic [3:0]  wb0_reg, wb1_reg;
    logic [31:0] wb0_data, wb1_data;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nb_lsu_scoreboard dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_kind(iss_kind),
        .iss_ra(iss_ra), .iss_ra_use(iss_ra_use),
        .iss_rb(iss_rb), .iss_rb_use(iss_rb_use),
        .iss_rd(iss_rd), .iss_rd_we(iss_rd_we),
        .iss_list(iss_list), .iss_addr(iss_addr), .iss_stall(iss_stall),
        .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_two(mem_two),
        .mem_reg0(mem_reg0), .mem_reg1(mem_reg1),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .wb0_en(wb0_en), .wb0_reg(wb0_reg), .wb0_data(wb0_data),
        .wb1_en(wb1_en), .wb1_reg(wb1_reg), .wb1_data(wb1_data)
    );

    function automatic logic [31:0] lo_word(input logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] hi_word(input logic [31:0] a);
        return ~a + 32'd7;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    task automatic alu_nodep();
        iss_valid = 1'b1; iss_kind = 2'd0;
        iss_ra_use = 1'b0; iss_rb_use = 1'b0; iss_rd_we = 1'b0;
    endtask

    task automatic issue_mem(input logic [1:0] k, input logic [15:0] l, input logic [31:0] a);
        iss_valid = 1'b1; iss_kind = k; iss_list = l; iss_addr = a;
        iss_ra_use = 1'b0; iss_rb_use = 1'b0; iss_rd_we = 1'b0;
    endtask

    // issue a load list, walk all its beats with lat wait cycles each
    task automatic run_load(input logic [15:0] l, input logic [31:0] base, input int lat);
        int arr[16];
        int n = 0;
        for (int i = 0; i < 16; i++) if (l[i]) begin arr[n] = i; n++; end
        @(negedge clk);
        issue_mem(2'd1, l, base);
        #1 chk("R7 idle accept", {63'd0, iss_stall}, 64'd0);
        @(negedge clk);
        alu_nodep();
        if (n == 0) begin
            #1 chk("R10 empty list no request", {63'd0, mem_req}, 64'd0);
        end
        for (int b = 0; b < (n + 1) / 2; b++) begin
            logic [31:0] ea;
            bit two;
            ea  = base + 32'(8 * b);
            two = (2 * b + 1 < n);
            for (int w = 0; w < lat; w++) begin
                #1;
                chk("R6 wait addr", {32'd0, mem_addr}, {32'd0, ea});
                chk("R6 wait no wb", {62'd0, wb0_en, wb1_en}, 64'd0);
                chk(l[15] ? "R8 pc lock stall" : "R2 no dep no stall",
                    {63'd0, iss_stall}, {63'd0, l[15]});
                @(negedge clk);
            end
            mem_ready = 1'b1;
            mem_rdata = {hi_word(ea), lo_word(ea)};
            #1;
            chk("R5 beat addr", {32'd0, mem_addr}, {32'd0, ea});
            chk("R5 pair flag", {63'd0, mem_two}, {63'd0, two});
            chk("R11 wb0 enable", {63'd0, wb0_en}, 64'd1);
            chk("R5 wb0 reg", {60'd0, wb0_reg}, 64'(arr[2 * b]));
            chk("R11 wb0 data", {32'd0, wb0_data}, {32'd0, lo_word(ea)});
            chk("R5 wb1 enable", {63'd0, wb1_en}, {63'd0, two});
            if (two) begin
                chk("R5 wb1 reg", {60'd0, wb1_reg}, 64'(arr[2 * b + 1]));
                chk("R11 wb1 data", {32'd0, wb1_data}, {32'd0, hi_word(ea)});
            end
            chk(l[15] ? "R8 pc lock stall" : "R2 no dep no stall",
                {63'd0, iss_stall}, {63'd0, l[15]});
            @(negedge clk);
            mem_ready = 1'b0;
        end
        #1;
        chk("R5 done no request", {63'd0, mem_req}, 64'd0);
        chk("R8 issue resumes", {63'd0, iss_stall}, 64'd0);
        iss_valid = 1'b0;
    endtask

    task automatic probe(input string req, input logic [3:0] ra, input bit rause,
                         input logic [3:0] rd, input bit rdwe, input bit exp);
        iss_valid = 1'b1; iss_kind = 2'd0;
        iss_ra = ra; iss_ra_use = rause; iss_rb_use = 1'b0;
        iss_rd = rd; iss_rd_we = rdwe;
        #1 chk(req, {63'd0, iss_stall}, {63'd0, exp});
        @(negedge clk);
    endtask

    initial begin
        #500000;
        nvec++; nbad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [15:0] dl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset req", {63'd0, mem_req}, 64'd0);
        chk("R1 reset wb", {62'd0, wb0_en, wb1_en}, 64'd0);
        chk("R1 reset stall", {63'd0, iss_stall}, 64'd0);

        // sweep of every list over r0..r7, varying latency
        for (int v = 0; v < 256; v++)
            run_load(16'(v), 32'h1000 + 32'(v) * 32'd128, v % 3);
        // upper registers, including the program counter
        for (int v = 1; v < 256; v += 17)
            run_load(16'(v) << 8, 32'h8000 + 32'(v) * 32'd64, (v + 1) % 3);

        // dependency sweep against a known pending set
        dl = 16'b0001_0010_0001_0000; // r4, r9, r12
        @(negedge clk);
        issue_mem(2'd1, dl, 32'h4000);
        @(negedge clk);
        for (int r = 0; r < 16; r++)
            probe("R3 read pending", 4'(r), 1'b1, 4'd0, 1'b0, dl[r]);
        for (int r = 0; r < 16; r++)
            probe("R4 write pending", 4'd0, 1'b0, 4'(r), 1'b1, dl[r]);
        for (int r = 0; r < 16; r++)
            probe("R2 independent", 4'(r), 1'b0, 4'(r), 1'b0, 1'b0);
        issue_mem(2'd2, 16'h0001, 32'h0);
        #1 chk("R7 store while busy", {63'd0, iss_stall}, 64'd1);
        @(negedge clk);
        mem_ready = 1'b1;
        probe("R3 stall in write-back cycle", 4'd9, 1'b1, 4'd0, 1'b0, 1'b1);
        mem_ready = 1'b0;
        probe("R3 released after write-back", 4'd9, 1'b1, 4'd0, 1'b0, 1'b0);
        probe("R3 r12 still pending", 4'd12, 1'b1, 4'd0, 1'b0, 1'b1);
        mem_ready = 1'b1;
        probe("R11 last beat wb", 4'd0, 1'b0, 4'd0, 1'b0, 1'b0);
        mem_ready = 1'b0;
        probe("R3 r12 released", 4'd12, 1'b1, 4'd0, 1'b0, 1'b0);

        // store list r1, r2, r3
        issue_mem(2'd2, 16'h000E, 32'h200);
        @(negedge clk);
        iss_valid = 1'b0;
        #1;
        chk("R9 store dir", {63'd0, mem_wr}, 64'd1);
        chk("R9 store regs", {56'd0, mem_reg0, mem_reg1}, 64'h12);
        chk("R5 store pair", {63'd0, mem_two}, 64'd1);
        chk("R5 store base", {32'd0, mem_addr}, 64'h200);
        @(negedge clk);
        probe("R9 write unread reg", 4'd0, 1'b0, 4'd3, 1'b1, 1'b1);
        probe("R9 write other reg", 4'd0, 1'b0, 4'd5, 1'b1, 1'b0);
        probe("R9 read store reg", 4'd3, 1'b1, 4'd0, 1'b0, 1'b0);
        mem_ready = 1'b1;
        #1 chk("R9 store no wb", {62'd0, wb0_en, wb1_en}, 64'd0);
        @(negedge clk);
        mem_ready = 1'b0;
        #1;
        chk("R5 store odd beat reg", {60'd0, mem_reg0}, 64'd3);
        chk("R5 store odd beat single", {63'd0, mem_two}, 64'd0);
        chk("R5 store next addr", {32'd0, mem_addr}, 64'h208);
        probe("R9 read reg released", 4'd0, 1'b0, 4'd1, 1'b1, 1'b0);
        probe("R9 r3 still unread", 4'd0, 1'b0, 4'd3, 1'b1, 1'b1);
        issue_mem(2'd1, 16'h0001, 32'h0);
        #1 chk("R7 load while store busy", {63'd0, iss_stall}, 64'd1);
        mem_ready = 1'b1;
        #1 chk("R9 store no wb last", {62'd0, wb0_en, wb1_en}, 64'd0);
        @(negedge clk);
        mem_ready = 1'b0;
        iss_valid = 1'b0;
        #1 chk("R9 store done", {63'd0, mem_req}, 64'd0);
        probe("R9 r3 released", 4'd0, 1'b0, 4'd3, 1'b1, 1'b0);

        // empty store list
        issue_mem(2'd2, 16'h0000, 32'h300);
        #1 chk("R10 empty store accepted", {63'd0, iss_stall}, 64'd0);
        @(negedge clk);
        iss_valid = 1'b0;
        #1 chk("R10 empty store no request", {63'd0, mem_req}, 64'd0);
        @(negedge clk);
        report();
    end

endmodule